// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command writes that a host issues to a NOR-style flash device. Each bus write carries an address and a 16-bit word whose low byte holds the command code. Some commands take effect in one write: they pick what a read returns (array data, identifier, status, query), clear the error flags, or suspend or resume a running operation. Others need two writes, a setup and then a confirm or data write. Several of these share a setup code and are told apart by the second write.

Accepted program, erase, lock and protection-register operations go to an external write sequencer as a one-cycle `seq_start` pulse with an operation code, an address and a data word. The sequencer answers with `seq_busy`. While it is busy, the only write the block accepts is a suspend. An 8-bit status value combines a ready flag, the suspend flags and the error flags. It is captured into `status_q` when a read cycle opens, so it holds still while the host reads it. A program or erase is refused when the programming supply is reported invalid.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: With the sequencer ready and no setup pending, a write whose low byte is FFh, 90h, 70h or 98h sets `rd_mode` to 0 (array), 1 (identifier), 2 (status) or 3 (query). The new mode is visible one clock after the write.
- R2: Erase is 20h followed by D0h at an address in the same block (same `wr_addr[ADDR_W-1:BLK_LSB]`). One clock after the confirm, `seq_start` pulses for one cycle with `seq_op`=1 and `seq_addr` set to the confirm address.
- R3: Program is 40h or 10h followed by any write. `seq_start` pulses with `seq_op`=0, and `seq_addr`/`seq_data` carry the second write's address and data.
- R4: After setup code 60h, a second low byte of 01h starts `seq_op`=2 (lock), D0h starts `seq_op`=3 (unlock) and 2Fh starts `seq_op`=4 (lock-down).
- R5: After setup C0h, a second data word of FFFDh starts `seq_op`=6 (protection lock). Any other word starts `seq_op`=5 (protection program) carrying that word.
- R6: While `seq_busy` is high, a write with low byte B0h raises `susp_req` for one cycle. Every other write is ignored: no start, no mode change, no setup.
- R7: Status bit 7 is 1 when the sequencer is idle and no start is in flight. When a suspended operation stops, bit 6 (erase) or bit 2 (program) becomes 1. While suspended, setup codes are ignored, and D0h starts `seq_op`=7 (resume) and clears both suspend bits.
- R8: `status_q` is loaded when `oe_n` and `ce_n` are both sampled low after at least one of them was high, i.e. at the later of the two falling edges. It stays unchanged while both remain low.
- R9: After a program or erase is started, `rd_mode` stays 2 (status) until a new mode command is written.
- R10: If `vpp_ok` is low at the confirming write of a program-class operation (codes 0, 5, 6) or an erase, no start is issued. Status bit 3 is set, together with bit 4 (program) or bit 5 (erase), and `rd_mode` becomes 2.
- R11: A wrong second code after 20h or 60h, or an erase confirm in another block, sets status bits 4 and 5, returns `rd_mode` to 0 and issues no start.
- R12: Writing 50h clears status bits 3, 4 and 5.
- R13: After reset, `rd_mode` is 0, `seq_start` and `susp_req` are 0, and the status value is 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; command code in bits 7:0 |
| oe_n | input | 1 | Output enable, active low, sampled on clk |
| ce_n | input | 1 | Chip enable, active low, sampled on clk |
| vpp_ok | input | 1 | Programming supply within range |
| seq_busy | input | 1 | Write sequencer running |
| seq_start | output | 1 | One-cycle operation request |
| seq_op | output | 3 | Requested operation code |
| seq_addr | output | ADDR_W | Operation address |
| seq_data | output | DATA_W | Operation data word |
| susp_req | output | 1 | One-cycle suspend request |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 status, 3 query |
| status_q | output | 8 | Status value captured at read start |

## Verification
The assertions check four things on every cycle. No start is issued while the sequencer is busy. A suspend request always follows a busy cycle, and start and suspend never coincide. A program or erase start always had a valid supply on its confirming write. The captured status holds still during an open read, and a clear empties the error bits. The rest depends on particular write sequences and only the bench scenarios show it: confirm codes shared between commands, the wrong-confirm and wrong-block errors, setups ignored while suspended, status mode persisting after an operation, and which of the two enable edges does the capture.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_ERASE  = 3'd1,
    OP_LOCK   = 3'd2,
    OP_UNLOCK = 3'd3,
    OP_LOCKDN = 3'd4,
    OP_PRPROG = 3'd5,
    OP_PRLOCK = 3'd6,
    OP_RESUME = 3'd7
  } seq_op_e;

  typedef enum logic [3:0] {
    C_NONE, C_RD_ARRAY, C_RD_ID, C_RD_STAT, C_CLR_STAT, C_RD_QUERY,
    C_ERASE_SU, C_PROG_SU, C_LOCK_SU, C_PREG_SU, C_SUSPEND, C_CONFIRM
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE_CFM, ST_PROG_DATA, ST_LOCK_CFM, ST_PREG_DATA
  } fsm_e;

  localparam logic [7:0] CODE_CONFIRM  = 8'hD0;
  localparam logic [7:0] CODE_LOCK     = 8'h01;
  localparam logic [7:0] CODE_LOCKDN   = 8'h2F;
  localparam logic [15:0] WORD_PRLOCK  = 16'hFFFD;

  function automatic logic needs_supply(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_ERASE) ||
           (op == OP_PRPROG) || (op == OP_PRLOCK);
  endfunction

endpackage

// File: rtl/fci_decode.sv
module fci_decode
  import fci_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       cmd
);

  always_comb begin
    unique case (code)
      8'hFF:   cmd = C_RD_ARRAY;
      8'h90:   cmd = C_RD_ID;
      8'h70:   cmd = C_RD_STAT;
      8'h50:   cmd = C_CLR_STAT;
      8'h98:   cmd = C_RD_QUERY;
      8'h20:   cmd = C_ERASE_SU;
      8'h40,
      8'h10:   cmd = C_PROG_SU;
      8'h60:   cmd = C_LOCK_SU;
      8'hC0:   cmd = C_PREG_SU;
      8'hB0:   cmd = C_SUSPEND;
      8'hD0:   cmd = C_CONFIRM;
      default: cmd = C_NONE;
    endcase
  end

endmodule

// File: rtl/fci_status.sv
module fci_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_vpp,
  input  logic       set_pfail,
  input  logic       set_efail,
  input  logic       ready,
  input  logic       susp_e,
  input  logic       susp_p,
  input  logic       oe_n,
  input  logic       ce_n,
  output logic [7:0] status_q
);

  logic [2:0] err_q, err_d;   // {erase fail, program fail, supply error}
  logic       act_q;
  logic       rd_act, cap;
  logic [7:0] live;

  always_comb begin
    if (clr) err_d = '0;
    else     err_d = err_q | {set_efail, set_pfail, set_vpp};
  end

  assign live   = {ready, susp_e, err_q[2], err_q[1], err_q[0], susp_p, 2'b00};
  assign rd_act = ~oe_n & ~ce_n;
  assign cap    = rd_act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      act_q    <= 1'b0;
      status_q <= 8'h80;
    end else begin
      err_q <= err_d;
      act_q <= rd_act;
      if (cap) status_q <= live;
    end
  end

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rd_act) |=> $stable(status_q)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_q == 3'b000)); // R12

endmodule

// File: rtl/fci_fsm.sv
module fci_fsm
  import fci_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  cmd_e              cmd,
  input  logic              vpp_ok,
  input  logic              seq_busy,
  output logic              start_q,
  output logic [2:0]        op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              susp_req_q,
  output logic [1:0]        mode_q,
  output logic              ready,
  output logic              susp_e_q,
  output logic              susp_p_q,
  output logic              ev_clr,
  output logic              ev_vpp,
  output logic              ev_pfail,
  output logic              ev_efail
);

  localparam int BLK_W = ADDR_W - BLK_LSB;

  fsm_e              state_q, state_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [1:0]        mode_d;
  logic              start_d, susp_req_d;
  logic [2:0]        op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              pend_q, pend_d;
  logic              run_e_q, run_e_d;
  logic              busy_q;
  logic              susp_e_d, susp_p_d;
  logic              suspended;
  logic [7:0]        code;
  logic [BLK_W-1:0]  wr_blk;

  assign ready     = ~seq_busy & ~start_q;
  assign suspended = susp_e_q | susp_p_q;
  assign code      = wr_data[7:0];
  assign wr_blk    = wr_addr[ADDR_W-1:BLK_LSB];

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    blk_d      = blk_q;
    start_d    = 1'b0;
    susp_req_d = 1'b0;
    op_d       = op_q;
    addr_d     = addr_q;
    data_d     = data_q;
    pend_d     = pend_q;
    run_e_d    = run_e_q;
    susp_e_d   = susp_e_q;
    susp_p_d   = susp_p_q;
    ev_clr     = 1'b0;
    ev_vpp     = 1'b0;
    ev_pfail   = 1'b0;
    ev_efail   = 1'b0;

    // sequencer stopped after a suspend request
    if (busy_q && !seq_busy && pend_q) begin
      pend_d = 1'b0;
      if (run_e_q) susp_e_d = 1'b1;
      else         susp_p_d = 1'b1;
    end

    if (wr_en) begin
      if (!ready) begin
        if (cmd == C_SUSPEND && seq_busy && !pend_q) begin
          susp_req_d = 1'b1;
          pend_d     = 1'b1;
        end
      end else begin
        state_d = ST_IDLE;
        unique case (state_q)
          ST_IDLE: begin
            unique case (cmd)
              C_RD_ARRAY: mode_d = RM_ARRAY;
              C_RD_ID:    mode_d = RM_IDENT;
              C_RD_STAT:  mode_d = RM_STATUS;
              C_RD_QUERY: mode_d = RM_QUERY;
              C_CLR_STAT: ev_clr = 1'b1;
              C_ERASE_SU, C_PROG_SU, C_LOCK_SU, C_PREG_SU: begin
                if (!suspended) begin
                  mode_d = RM_STATUS;
                  blk_d  = wr_blk;
                  if (cmd == C_ERASE_SU)     state_d = ST_ERASE_CFM;
                  else if (cmd == C_PROG_SU) state_d = ST_PROG_DATA;
                  else if (cmd == C_LOCK_SU) state_d = ST_LOCK_CFM;
                  else                       state_d = ST_PREG_DATA;
                end
              end
              C_CONFIRM: begin
                if (suspended) begin
                  start_d  = 1'b1;
                  op_d     = OP_RESUME;
                  addr_d   = wr_addr;
                  data_d   = wr_data;
                  susp_e_d = 1'b0;
                  susp_p_d = 1'b0;
                  mode_d   = RM_STATUS;
                end
              end
              default: ;
            endcase
          end
          ST_ERASE_CFM: begin
            if (code == CODE_CONFIRM && wr_blk == blk_q) begin
              op_d = OP_ERASE;
            end else begin
              op_d = OP_RESUME;   // marks an invalid sequence below
            end
          end
          ST_PROG_DATA: op_d = OP_PROG;
          ST_LOCK_CFM: begin
            if (code == CODE_LOCK)          op_d = OP_LOCK;
            else if (code == CODE_CONFIRM)  op_d = OP_UNLOCK;
            else if (code == CODE_LOCKDN)   op_d = OP_LOCKDN;
            else                            op_d = OP_RESUME;
          end
          ST_PREG_DATA: begin
            if (wr_data == DATA_W'(WORD_PRLOCK)) op_d = OP_PRLOCK;
            else                                 op_d = OP_PRPROG;
          end
          default: state_d = ST_IDLE;
        endcase

        // second-cycle outcome
        if (state_q != ST_IDLE) begin
          if (op_d == OP_RESUME) begin
            op_d     = op_q;
            ev_pfail = 1'b1;
            ev_efail = 1'b1;
            mode_d   = RM_ARRAY;
          end else begin
            mode_d = RM_STATUS;
            if (needs_supply(op_d) && !vpp_ok) begin
              ev_vpp = 1'b1;
              if (op_d == OP_ERASE) ev_efail = 1'b1;
              else                  ev_pfail = 1'b1;
              op_d = op_q;
            end else begin
              start_d = 1'b1;
              addr_d  = wr_addr;
              data_d  = wr_data;
              run_e_d = (op_d == OP_ERASE);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= RM_ARRAY;
      blk_q      <= '0;
      start_q    <= 1'b0;
      susp_req_q <= 1'b0;
      op_q       <= OP_PROG;
      addr_q     <= '0;
      data_q     <= '0;
      pend_q     <= 1'b0;
      run_e_q    <= 1'b0;
      busy_q     <= 1'b0;
      susp_e_q   <= 1'b0;
      susp_p_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      blk_q      <= blk_d;
      start_q    <= start_d;
      susp_req_q <= susp_req_d;
      op_q       <= op_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      pend_q     <= pend_d;
      run_e_q    <= run_e_d;
      busy_q     <= seq_busy;
      susp_e_q   <= susp_e_d;
      susp_p_q   <= susp_p_d;
    end
  end

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !start_q); // R6

  AST_SUSPEND_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req_q |-> $past(seq_busy)); // R6

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_q, susp_req_q})); // R6

  AST_SUPPLY_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && needs_supply(op_q)) |-> $past(vpp_ok)); // R10

  AST_SUSPEND_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(susp_e_q) || $rose(susp_p_q)) |-> $past(pend_q)); // R7

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              oe_n,
  input  logic              ce_n,
  input  logic              vpp_ok,
  input  logic              seq_busy,
  output logic              seq_start,
  output logic [2:0]        seq_op,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_data,
  output logic              susp_req,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status_q
);

  cmd_e cmd;
  logic ready, susp_e, susp_p;
  logic ev_clr, ev_vpp, ev_pfail, ev_efail;

  fci_decode u_dec (
    .code (wr_data[7:0]),
    .cmd  (cmd)
  );

  fci_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BLK_LSB (BLK_LSB)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmd        (cmd),
    .vpp_ok     (vpp_ok),
    .seq_busy   (seq_busy),
    .start_q    (seq_start),
    .op_q       (seq_op),
    .addr_q     (seq_addr),
    .data_q     (seq_data),
    .susp_req_q (susp_req),
    .mode_q     (rd_mode),
    .ready      (ready),
    .susp_e_q   (susp_e),
    .susp_p_q   (susp_p),
    .ev_clr     (ev_clr),
    .ev_vpp     (ev_vpp),
    .ev_pfail   (ev_pfail),
    .ev_efail   (ev_efail)
  );

  fci_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_clr),
    .set_vpp   (ev_vpp),
    .set_pfail (ev_pfail),
    .set_efail (ev_efail),
    .ready     (ready),
    .susp_e    (susp_e),
    .susp_p    (susp_p),
    .oe_n      (oe_n),
    .ce_n      (ce_n),
    .status_q  (status_q)
  );

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          oe_n = 1'b1, ce_n = 1'b1, vpp_ok = 1'b1;
  logic          seq_busy;
  logic          seq_start, susp_req;
  logic [2:0]    seq_op;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic [1:0]    rd_mode;
  logic [7:0]    status_q;
  int            n_chk = 0, n_bad = 0;
  int            cnt;

  always #10 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oe_n(oe_n), .ce_n(ce_n), .vpp_ok(vpp_ok), .seq_busy(seq_busy),
    .seq_start(seq_start), .seq_op(seq_op), .seq_addr(seq_addr), .seq_data(seq_data),
    .susp_req(susp_req), .rd_mode(rd_mode), .status_q(status_q)
  );

  // sequencer model: busy for 20 cycles, stops early on suspend
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_busy <= 1'b0; cnt <= 0;
    end else if (seq_start) begin
      seq_busy <= 1'b1; cnt <= 20;
    end else if (seq_busy) begin
      if (susp_req || cnt == 0) seq_busy <= 1'b0;
      else cnt <= cnt - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] s);
    @(negedge clk);
    oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    s = status_q;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (seq_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R13 mode", rd_mode, 0);
    chk("R13 start", {seq_start, susp_req}, 0);
    rd_stat(s);
    chk("R13 status", s, 8'h80);
  endtask

  task automatic t_modes();
    wr(0, 16'h0090); chk("R1 ident", rd_mode, 1);
    wr(0, 16'h0070); chk("R1 status", rd_mode, 2);
    wr(0, 16'h0098); chk("R1 query", rd_mode, 3);
    wr(0, 16'h00FF); chk("R1 array", rd_mode, 0);
  endtask

  task automatic t_erase();
    logic [7:0] s;
    wr(21'h1_0000, 16'h0020);
    chk("R2 no start on setup", seq_start, 0);
    wr(21'h1_0123, 16'h00D0);
    chk("R2 start", seq_start, 1);
    chk("R2 op", seq_op, 1);
    chk("R2 addr", seq_addr, 21'h1_0123);
    chk("R9 mode", rd_mode, 2);
    rd_stat(s);
    chk("R7 busy status", s, 8'h00);
    wait_idle();
    rd_stat(s);
    chk("R7 ready status", s, 8'h80);
    chk("R9 mode kept", rd_mode, 2);
    wr(0, 16'h00FF);
    chk("R9 new command", rd_mode, 0);
  endtask

  task automatic t_program();
    wr(21'h0_0004, 16'h0040);
    wr(21'h0_1234, 16'hBEEF);
    chk("R3 start", seq_start, 1);
    chk("R3 op", seq_op, 0);
    chk("R3 addr", seq_addr, 21'h0_1234);
    chk("R3 data", seq_data, 16'hBEEF);
    wait_idle();
    wr(0, 16'h0010);
    wr(21'h0_0042, 16'h1357);
    chk("R3 alt setup", {seq_start, seq_op, seq_data}, {1'b1, 3'd0, 16'h1357});
    wait_idle();
  endtask

  task automatic t_lock();
    wr(21'h2_0000, 16'h0060); wr(21'h2_0000, 16'h0001);
    chk("R4 lock", {seq_start, seq_op}, {1'b1, 3'd2});
    wait_idle();
    wr(21'h2_0000, 16'h0060); wr(21'h2_0000, 16'h00D0);
    chk("R4 unlock", {seq_start, seq_op}, {1'b1, 3'd3});
    wait_idle();
    wr(21'h2_0000, 16'h0060); wr(21'h2_0000, 16'h002F);
    chk("R4 lockdown", {seq_start, seq_op}, {1'b1, 3'd4});
    wait_idle();
  endtask

  task automatic t_preg();
    wr(21'h80, 16'h00C0); wr(21'h80, 16'hFFFD);
    chk("R5 prot lock", {seq_start, seq_op}, {1'b1, 3'd6});
    wait_idle();
    wr(21'h81, 16'h00C0); wr(21'h81, 16'h5555);
    chk("R5 prot prog", {seq_start, seq_op, seq_data}, {1'b1, 3'd5, 16'h5555});
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    wr(0, 16'h0040); wr(21'h10, 16'h0001);
    wr(0, 16'h00FF);
    chk("R6 mode unchanged", rd_mode, 2);
    wr(0, 16'h0040);
    wr(21'h11, 16'h0002);
    chk("R6 no start while busy", {seq_start, susp_req}, 0);
    wait_idle();
    // the ignored 40h must not have left a setup behind
    wr(0, 16'h0098);
    chk("R6 no stale setup", {seq_start, rd_mode}, {1'b0, 2'd3});
    wr(0, 16'h00FF);
  endtask

  task automatic t_suspend();
    logic [7:0] s;
    wr(21'h3_0000, 16'h0020); wr(21'h3_0000, 16'h00D0);
    @(negedge clk);
    wr(0, 16'h00B0);
    chk("R6 suspend req", susp_req, 1);
    repeat (2) @(negedge clk);
    rd_stat(s);
    chk("R7 erase suspended", s, 8'hC0);
    wr(0, 16'h00FF);
    chk("R7 mode cmd while suspended", rd_mode, 0);
    wr(0, 16'h0040);
    wr(21'h3_0000, 16'h00D0);
    chk("R7 resume", {seq_start, seq_op}, {1'b1, 3'd7});
    rd_stat(s);
    chk("R7 flags cleared", s, 8'h00);
    wait_idle();
    wr(0, 16'h0040); wr(21'h20, 16'h0F0F);
    @(negedge clk);
    wr(0, 16'h00B0);
    repeat (2) @(negedge clk);
    rd_stat(s);
    chk("R7 program suspended", s, 8'h84);
    wr(0, 16'h00D0);
    chk("R7 resume program", {seq_start, seq_op}, {1'b1, 3'd7});
    wait_idle();
  endtask

  task automatic t_vpp();
    logic [7:0] s;
    vpp_ok = 1'b0;
    wr(0, 16'h0040); wr(21'h30, 16'h1111);
    chk("R10 no program start", seq_start, 0);
    chk("R10 mode", rd_mode, 2);
    rd_stat(s);
    chk("R10 program bits", s, 8'h98);
    wr(0, 16'h0050);
    rd_stat(s);
    chk("R12 clear", s, 8'h80);
    wr(0, 16'h0020); wr(0, 16'h00D0);
    chk("R10 no erase start", seq_start, 0);
    rd_stat(s);
    chk("R10 erase bits", s, 8'hA8);
    vpp_ok = 1'b1;
    wr(0, 16'h0050);
  endtask

  task automatic t_bad_seq();
    logic [7:0] s;
    wr(0, 16'h0070);
    wr(0, 16'h0020); wr(0, 16'h00FF);
    chk("R11 no start", seq_start, 0);
    chk("R11 mode array", rd_mode, 0);
    rd_stat(s);
    chk("R11 bits", s, 8'hB0);
    wr(0, 16'h0050);
    wr(21'h0_0000, 16'h0020); wr(21'h0_8000, 16'h00D0);
    chk("R11 other block", {seq_start, rd_mode}, {1'b0, 2'd0});
    rd_stat(s);
    chk("R11 other block bits", s, 8'hB0);
    wr(0, 16'h0050);
    wr(0, 16'h0060); wr(0, 16'h0055);
    rd_stat(s);
    chk("R11 bad lock code", s, 8'hB0);
    wr(0, 16'h0050);
    rd_stat(s);
    chk("R12 clear again", s, 8'h80);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    @(negedge clk); ce_n = 1'b0;
    repeat (3) @(negedge clk);
    wr(0, 16'h0040); wr(21'h40, 16'h2222);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    chk("R8 captured at later edge", status_q, 8'h00);
    while (seq_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 held while open", status_q, 8'h00);
    oe_n = 1'b1; ce_n = 1'b1;
    rd_stat(s);
    chk("R8 new read", s, 8'h80);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_erase();
        t_program();
        t_lock();
        t_preg();
        t_busy_ignore();
        t_suspend();
        t_vpp();
        t_bad_seq();
        t_latch();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule